// File: doc/BRIEF.md
# USB Host Interrupt Status Capture

This block holds the interrupt status word of a full/low-speed USB host controller. Single-cycle event strobes from the controller set sticky bits, which stay set until software clears them. Software clears a bit by writing 1 to its position through a one-cycle register write port. The block derives some events on its own. It watches the top bit of the frame counter for a toggle in either direction, and it turns the resume-signalling level into a rising-edge event. That edge event is suppressed while software has the controller in a commanded resume state.

Two status bits feed back into the controller. While the done-queue writeback bit is set, further writebacks are held off through an interlock output. While the system-error bit is set, a halt output stays high, and only controller reset clears it. Each scheduling overrun also advances a 2-bit counter that wraps and is readable on its own output. Interrupt masking and interrupt-line generation sit outside this block.

Top module: `usb_irq_status_capture`

## Requirements
- R1: The status word places overrun at bit 0, writeback-done at bit 1, frame-start at bit 2, resume at bit 3, system error at bit 4, frame overflow at bit 5, root-hub change at bit 6 and ownership change at bit 30. Bits 7 to 29 and bit 31 always read 0, and every bit is 0 after reset.
- R2: Bit 5 sets when bit 15 of the 16-bit frame number differs from its value one cycle earlier, in either direction, or on the shared-memory frame-number write strobe. A change in any lower frame bit alone does not set it.
- R3: Bit 3 sets only when the resume level goes from 0 to 1 while the software-resume input is 0. A level that stays high does not set it again.
- R4: Bit 1 sets on the writeback-done strobe, and the writeback-allowed output is the inverse of bit 1. It stays low until software clears bit 1.
- R5: Each overrun strobe sets bit 0 and adds 1 to the 2-bit overrun count, which wraps from 3 to 0. The count changes on nothing else, and writes do not clear it; only reset does.
- R6: Bit 30 sets on the ownership-change strobe when the management-interrupt option is enabled. It is held at 0 when the option is disabled.
- R7: Bit 2 sets on the frame-start strobe and bit 6 sets on the root-hub change strobe. Every status bit shows its event in the cycle after the strobe.
- R8: Bit 4 sets on the system-error strobe and drives the halt output high. Register writes cannot clear it; only reset does.
- R9: A write with a 1 in a clearable bit position clears that bit. Writing 0 changes nothing, and 1s written to reserved positions have no effect.
- R10: If a bit's set event and its write-1 clear fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| sof_pulse | input | 1 | Frame-start strobe |
| fn_mem_wr_pulse | input | 1 | Frame number written to shared memory |
| frame_num | input | 16 | Current frame number |
| resume_lvl | input | 1 | Resume signalling seen on the bus |
| sw_resume_state | input | 1 | Controller is in a software-commanded resume |
| rh_change_pulse | input | 1 | Root-hub or port status changed |
| sys_err_pulse | input | 1 | Non-USB system error |
| done_wb_pulse | input | 1 | Done-queue head written back to memory |
| sched_ovr_pulse | input | 1 | Schedule overran its frame |
| own_chg_pulse | input | 1 | Software requested an ownership change |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 32 | Write-1-to-clear data |
| status_word | output | 32 | Status word |
| ovr_count | output | 2 | Wrapping overrun count |
| wb_allowed | output | 1 | Done-queue writer may write back |
| halt_req | output | 1 | Controller must stop processing |

## Verification
The properties assume the writeback-done strobe arrives only while writeback is allowed, and that every strobe is low while reset is asserted. The frame-overflow property also assumes the frame number is steady for the first cycle after reset. The bench drives strobes for exactly one cycle, on the falling edge. It raises writeback-done only from a cleared state and holds the frame number at 0 through every reset.

// File: rtl/usbh_ists_pkg.sv
package usbh_ists_pkg;
   localparam int unsigned STATUS_W = 32;
   localparam int unsigned NUM_SRC  = 8;

   typedef enum int unsigned {
      SRC_OVR   = 0,
      SRC_WBD   = 1,
      SRC_SOF   = 2,
      SRC_RES   = 3,
      SRC_ERR   = 4,
      SRC_FOVF  = 5,
      SRC_RHUB  = 6,
      SRC_OWN   = 7
   } src_e;

   // Position of each source inside the status word.
   function automatic int unsigned src_pos(input int unsigned s);
      case (s)
         SRC_OVR:  return 0;
         SRC_WBD:  return 1;
         SRC_SOF:  return 2;
         SRC_RES:  return 3;
         SRC_ERR:  return 4;
         SRC_FOVF: return 5;
         SRC_RHUB: return 6;
         default:  return 30;
      endcase
   endfunction

   function automatic logic [STATUS_W-1:0] live_mask();
      logic [STATUS_W-1:0] m;
      m = '0;
      for (int unsigned s = 0; s < NUM_SRC; s++) m[src_pos(s)] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/usbh_sticky_cell.sv
module usbh_sticky_cell #(
   parameter bit CLR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic clr_eff;

   generate
      if (CLR_EN) begin : g_clr
         assign clr_eff = clr_i;
      end else begin : g_noclr
         logic unused_clr;
         assign unused_clr = clr_i;
         assign clr_eff    = 1'b0;
      end
   endgenerate

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_eff);
   end
endmodule

// File: rtl/usbh_msb_toggle.sv
module usbh_msb_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic msb_i,
   output logic toggle_o
);
   logic prev_q;
   logic primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= msb_i;
         primed_q <= 1'b1;
      end
   end

   assign toggle_o = primed_q & (msb_i ^ prev_q);
endmodule

// File: rtl/usbh_resume_edge.sv
module usbh_resume_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic suppress_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q & ~suppress_i;
endmodule

// File: rtl/usbh_wrap_counter.sv
module usbh_wrap_counter #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
   end
endmodule

// File: rtl/usb_irq_status_capture.sv
module usb_irq_status_capture
   import usbh_ists_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 2,
   parameter bit          HAS_SMI = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sof_pulse,
   input  logic                fn_mem_wr_pulse,
   input  logic [FRAME_W-1:0]  frame_num,
   input  logic                resume_lvl,
   input  logic                sw_resume_state,
   input  logic                rh_change_pulse,
   input  logic                sys_err_pulse,
   input  logic                done_wb_pulse,
   input  logic                sched_ovr_pulse,
   input  logic                own_chg_pulse,
   input  logic                reg_wr_en,
   input  logic [STATUS_W-1:0] reg_wr_data,
   output logic [STATUS_W-1:0] status_word,
   output logic [CNT_W-1:0]    ovr_count,
   output logic                wb_allowed,
   output logic                halt_req
);
   localparam int unsigned MSB = FRAME_W - 1;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] bit_q;
   logic               fovf_toggle;
   logic               res_rise;

   usbh_msb_toggle u_fovf (
      .clk      (clk),
      .rst_n    (rst_n),
      .msb_i    (frame_num[MSB]),
      .toggle_o (fovf_toggle)
   );

   usbh_resume_edge u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (resume_lvl),
      .suppress_i (sw_resume_state),
      .rise_o     (res_rise)
   );

   usbh_wrap_counter #(.CNT_W(CNT_W)) u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (sched_ovr_pulse),
      .cnt_o (ovr_count)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[SRC_OVR]  = sched_ovr_pulse;
      set_vec[SRC_WBD]  = done_wb_pulse;
      set_vec[SRC_SOF]  = sof_pulse;
      set_vec[SRC_RES]  = res_rise;
      set_vec[SRC_ERR]  = sys_err_pulse;
      set_vec[SRC_FOVF] = fovf_toggle | fn_mem_wr_pulse;
      set_vec[SRC_RHUB] = rh_change_pulse;
      set_vec[SRC_OWN]  = own_chg_pulse;
   end

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_src
         localparam int unsigned POS = src_pos(s);
         assign clr_vec[s] = reg_wr_en & reg_wr_data[POS];
         if (s == SRC_OWN && !HAS_SMI) begin : g_tied
            logic unused_src;
            assign unused_src = set_vec[s] ^ clr_vec[s];
            assign bit_q[s]   = 1'b0;
         end else begin : g_cell
            usbh_sticky_cell #(.CLR_EN(s != SRC_ERR)) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[s]),
               .clr_i (clr_vec[s]),
               .q_o   (bit_q[s])
            );
         end
      end
   endgenerate

   always_comb begin
      status_word = '0;
      for (int unsigned k = 0; k < NUM_SRC; k++) status_word[src_pos(k)] = bit_q[k];
   end

   assign wb_allowed = ~bit_q[SRC_WBD];
   assign halt_req   = bit_q[SRC_ERR];

   logic unused_bits;
   assign unused_bits = ^{reg_wr_data, frame_num};
endmodule

// File: rtl/usbh_ists_chk.sv
module usbh_ists_chk
   import usbh_ists_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 2,
   parameter bit          HAS_SMI = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sof_pulse,
   input logic                fn_mem_wr_pulse,
   input logic [FRAME_W-1:0]  frame_num,
   input logic                resume_lvl,
   input logic                sw_resume_state,
   input logic                rh_change_pulse,
   input logic                sys_err_pulse,
   input logic                done_wb_pulse,
   input logic                sched_ovr_pulse,
   input logic                own_chg_pulse,
   input logic                reg_wr_en,
   input logic [STATUS_W-1:0] reg_wr_data,
   input logic [STATUS_W-1:0] status_word,
   input logic [CNT_W-1:0]    ovr_count,
   input logic                wb_allowed,
   input logic                halt_req
);
   localparam logic [STATUS_W-1:0] RSVD = ~live_mask();
   localparam int unsigned MSB = FRAME_W - 1;

   logic live, live2;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live  <= 1'b0;
         live2 <= 1'b0;
      end else begin
         live  <= 1'b1;
         live2 <= live;
      end
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word & RSVD) == '0); // R1
   AST_FOVF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      live2 && ($past(frame_num[MSB]) != $past(frame_num[MSB], 2)) |-> status_word[5]); // R2
   AST_RES_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      live && $rose(status_word[3]) |-> $past(resume_lvl) && !$past(sw_resume_state)); // R3
   AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(!wb_allowed && !(reg_wr_en && reg_wr_data[1])) |-> !wb_allowed); // R4
   AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(sched_ovr_pulse) |-> ovr_count == CNT_W'($past(ovr_count) + 1'b1)); // R5
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      live && !$past(sched_ovr_pulse) |-> $stable(ovr_count)); // R5
   generate
      if (HAS_SMI) begin : g_own
         AST_OWN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            live && $past(own_chg_pulse) |-> status_word[30]); // R6
      end else begin : g_noown
         AST_OWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            live |-> !status_word[30]); // R6
      end
   endgenerate
   AST_SOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(sof_pulse) |-> status_word[2]); // R7
   AST_RHUB_SET: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(rh_change_pulse) |-> status_word[6]); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(status_word[4]) |-> status_word[4] && halt_req); // R8
   AST_W1C_SOF: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(reg_wr_en && reg_wr_data[2] && !sof_pulse) |-> !status_word[2]); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(sched_ovr_pulse && reg_wr_en && reg_wr_data[0]) |-> status_word[0]); // R10

   logic unused_chk;
   assign unused_chk = ^{fn_mem_wr_pulse, sys_err_pulse, done_wb_pulse, frame_num};
endmodule

bind usb_irq_status_capture usbh_ists_chk #(
   .FRAME_W (FRAME_W),
   .CNT_W   (CNT_W),
   .HAS_SMI (HAS_SMI)
) u_chk (.*);

// File: tb/tb_usb_irq_status_capture.sv
`timescale 1ns/1ps
module tb_usb_irq_status_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof_pulse = 0, fn_mem_wr_pulse = 0, resume_lvl = 0, sw_resume_state = 0;
   logic        rh_change_pulse = 0, sys_err_pulse = 0, done_wb_pulse = 0;
   logic        sched_ovr_pulse = 0, own_chg_pulse = 0, reg_wr_en = 0;
   logic [15:0] frame_num = '0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] status_word;
   logic [1:0]  ovr_count;
   logic        wb_allowed, halt_req;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   usb_irq_status_capture dut (.*);

   typedef struct packed {
      logic [3:0]  ev;   // [0]=overrun [1]=writeback [2]=frame start [3]=root hub
      logic        wr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [1:0]  cnt;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{4'b0001, 1'b0, 32'h0,        32'h01, 2'd1},  // R5 overrun
      '{4'b0100, 1'b0, 32'h0,        32'h05, 2'd1},  // R7 frame start
      '{4'b1000, 1'b0, 32'h0,        32'h45, 2'd1},  // R7 root hub
      '{4'b0010, 1'b0, 32'h0,        32'h47, 2'd1},  // R4 writeback
      '{4'b0000, 1'b1, 32'h04,       32'h43, 2'd1},  // R9 clear one
      '{4'b0001, 1'b1, 32'h01,       32'h43, 2'd2},  // R10 set wins
      '{4'b0000, 1'b1, 32'hFFFFFF80, 32'h43, 2'd2},  // R9 reserved writes
      '{4'b0000, 1'b1, 32'h0,        32'h43, 2'd2},  // R9 zero write
      '{4'b0001, 1'b0, 32'h0,        32'h43, 2'd3},  // R5
      '{4'b0001, 1'b0, 32'h0,        32'h43, 2'd0},  // R5 wrap
      '{4'b0000, 1'b1, 32'h43,       32'h00, 2'd0},  // R9 clear all
      '{4'b1111, 1'b0, 32'h0,        32'h47, 2'd1},  // R7 together
      '{4'b0000, 1'b1, 32'h47,       32'h00, 2'd1}   // R4 release
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      sof_pulse = 0; fn_mem_wr_pulse = 0; rh_change_pulse = 0; sys_err_pulse = 0;
      done_wb_pulse = 0; sched_ovr_pulse = 0; own_chg_pulse = 0; reg_wr_en = 0;
      reg_wr_data = '0;
   endtask

   task automatic wclr(input logic [31:0] d);
      reg_wr_en = 1; reg_wr_data = d;
      cyc();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset status", status_word, 32'h0);
      chk("R5 reset count", {30'h0, ovr_count}, 32'h0);
      chk("R4 reset wb_allowed", {31'h0, wb_allowed}, 32'h1);
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 13; i++) begin
         sched_ovr_pulse = VECS[i].ev[0];
         done_wb_pulse   = VECS[i].ev[1];
         sof_pulse       = VECS[i].ev[2];
         rh_change_pulse = VECS[i].ev[3];
         reg_wr_en       = VECS[i].wr;
         reg_wr_data     = VECS[i].wd;
         cyc();
         chk($sformatf("R7/R9/R10 vec%0d status", i), status_word, VECS[i].exp);
         chk($sformatf("R5 vec%0d count", i), {30'h0, ovr_count}, {30'h0, VECS[i].cnt});
         chk($sformatf("R4 vec%0d wb_allowed", i), {31'h0, wb_allowed}, {31'h0, ~VECS[i].exp[1]});
      end

      // R2 frame overflow
      frame_num = 16'h7FFF; cyc();
      chk("R2 low bits only", status_word, 32'h0);
      frame_num = 16'h8000; cyc();
      chk("R2 rising msb", status_word, 32'h20);
      wclr(32'h20);
      frame_num = 16'h8001; cyc();
      chk("R2 msb steady", status_word, 32'h0);
      frame_num = 16'h0000; cyc();
      chk("R2 falling msb", status_word, 32'h20);
      wclr(32'h20);
      fn_mem_wr_pulse = 1; cyc();
      chk("R2 memory write", status_word, 32'h20);
      wclr(32'h20);

      // R3 resume
      sw_resume_state = 1; resume_lvl = 1; cyc();
      chk("R3 suppressed", status_word, 32'h0);
      sw_resume_state = 0; resume_lvl = 0; cyc();
      resume_lvl = 1; cyc();
      chk("R3 edge", status_word, 32'h08);
      wclr(32'h08);
      cyc();
      chk("R3 level held", status_word, 32'h0);
      resume_lvl = 0; cyc();

      // R6 ownership change
      own_chg_pulse = 1; cyc();
      chk("R6 ownership", status_word, 32'h40000000);
      wclr(32'h40000000);
      chk("R6 cleared", status_word, 32'h0);

      // R8 system error
      sys_err_pulse = 1; cyc();
      chk("R8 error set", status_word, 32'h10);
      chk("R8 halt", {31'h0, halt_req}, 32'h1);
      wclr(32'h10);
      chk("R8 write ignored", status_word, 32'h10);
      rst_n = 0; cyc(); cyc();
      chk("R8 reset clears", status_word, 32'h0);
      chk("R8 halt released", {31'h0, halt_req}, 32'h0);
      chk("R5 count reset", {30'h0, ovr_count}, 32'h0);
      rst_n = 1; cyc();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule